// File: doc/BRIEF.md
# Timeslot-Classified Receive Byte Router

This block sits behind a serial framer and takes one received byte per timeslot, along with that timeslot's index. A programmable table holds one entry per timeslot and sorts every incoming byte into one of four classes. Bytes in unassigned slots are thrown away. Bytes in voice slots and in 56-K mode slots are packed into a shared voice buffer. Bytes in HDLC slots are packed into one of four HDLC channel buffers, and the channel is picked by the low two bits of the timeslot index.

Every buffer is split into two halves that work in ping-pong fashion. The receive side fills one half while a consumer drains the other. A voice half is two 32-bit words and is presented to the consumer as a single 64-bit read. An HDLC half is one 32-bit word. The consumer sees a ready flag for each buffer and the contents of the oldest complete half. It then pulses an acknowledge to release that half. A programmable frame size limits how many table entries are live.

Top module: `ts_byte_router`

## Requirements
- R1: A table write (`lut_we`, `lut_addr`, `lut_class`) sets the class of one timeslot and applies to every later byte of that slot. The class codes are 0 = unassigned, 1 = voice, 2 = HDLC and 3 = 56-K mode.
- R2: A byte whose slot is classed unassigned is discarded and reaches no buffer.
- R3: Voice and 56-K bytes both go into the voice buffer. They are packed least-significant byte first, so the first byte of a half lands in `voice_rd_data[7:0]`, the fifth byte in bits 39:32 and the eighth byte in bits 63:56.
- R4: An HDLC byte goes to the channel equal to `in_slot[1:0]`. Each channel half is one word, with its first byte in bits 7:0 of that channel's 32-bit slice of `hdlc_rd_data`; channel c occupies bits 32c+31 to 32c.
- R5: Bytes in slots at or above the programmed frame size are discarded. A frame size of 0 makes all 128 slots live.
- R6: When a half becomes full, its ready flag rises and filling moves to the other half. The flag and the read data stay unchanged until acknowledge. Acknowledge then presents the other half, in fill order.
- R7: If a half becomes full while the other half is still unacknowledged, that buffer's overflow flag is set. Bytes for that buffer are then dropped until the next acknowledge, which clears the flag.
- R8: After reset, all ready and overflow flags are low, every table entry is unassigned and the frame size is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lut_we | input | 1 | Table entry write strobe |
| lut_addr | input | 7 | Timeslot whose entry is written |
| lut_class | input | 2 | Class code written |
| fsize_we | input | 1 | Frame size write strobe |
| fsize | input | 7 | Frame size value (0 = 128) |
| in_valid | input | 1 | Received byte present |
| in_slot | input | 7 | Timeslot index of the byte |
| in_byte | input | 8 | Received byte |
| voice_rdy | output | 1 | A voice half is complete |
| voice_rd_data | output | 64 | The two words of the oldest voice half |
| voice_ack | input | 1 | Releases the presented voice half |
| voice_ovf | output | 1 | Voice overflow flag |
| hdlc_rdy | output | 4 | Per-channel HDLC half complete |
| hdlc_rd_data | output | 128 | One 32-bit word per channel |
| hdlc_ack | input | 4 | Per-channel release |
| hdlc_ovf | output | 4 | Per-channel overflow flag |

## Verification
The bench builds the block with its default parameters: 7-bit slot index, four HDLC channels, two words per voice half and one word per HDLC half. This makes the full 128-slot frame reachable, so the meaning of a zero frame size can be tested at slot 127. A 12-slot frame with entries programmed past its end shows that the frame limit discards bytes. The one-word HDLC halves make overflow quick to provoke, since eight bytes to one channel with no acknowledge are enough.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [1:0] {
        SC_NONE  = 2'd0,
        SC_VOICE = 2'd1,
        SC_HDLC  = 2'd2,
        SC_K56   = 2'd3
    } slot_class_t;
endpackage

// File: rtl/rxr_class_table.sv
module rxr_class_table
    import rxr_pkg::*;
#(
    parameter int SLOT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SLOT_W-1:0] waddr,
    input  logic [1:0]        wclass,
    input  logic              fs_we,
    input  logic [SLOT_W-1:0] fs_val,
    input  logic [SLOT_W-1:0] look_slot,
    output slot_class_t       look_class
);
    localparam int SLOTS = 1 << SLOT_W;

    slot_class_t       tbl_d [SLOTS];
    slot_class_t       tbl_q [SLOTS];
    logic [SLOT_W-1:0] fs_d, fs_q;
    logic [SLOT_W:0]   live_cnt;

    always_comb begin
        tbl_d = tbl_q;
        fs_d  = fs_q;
        if (we)    tbl_d[waddr] = slot_class_t'(wclass);
        if (fs_we) fs_d = fs_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '{default: SC_NONE};
            fs_q  <= '0;
        end else begin
            tbl_q <= tbl_d;
            fs_q  <= fs_d;
        end
    end

    // Zero frame size selects every slot
    assign live_cnt   = (fs_q == '0) ? (SLOT_W+1)'(SLOTS) : {1'b0, fs_q};
    assign look_class = ({1'b0, look_slot} < live_cnt) ? tbl_q[look_slot] : SC_NONE;
endmodule

// File: rtl/rxr_pingpong.sv
module rxr_pingpong #(
    parameter int WORDS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [7:0]        wbyte,
    input  logic              ack,
    output logic              rdy,
    output logic [WORDS*32-1:0] rd_data,
    output logic              ovf
);
    localparam int HB   = WORDS * 32;
    localparam int NB   = WORDS * 4;
    localparam int CW   = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [CW-1:0] LAST = CW'(NB - 1);

    typedef struct packed {
        logic                 fill;
        logic                 rdp;
        logic [1:0]           full;
        logic                 ovf;
        logic [CW-1:0]        cnt;
        logic [1:0][HB-1:0]   data;
    } pp_t;

    pp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack && st_q.full[st_q.rdp]) begin
            st_d.full[st_q.rdp] = 1'b0;
            st_d.rdp            = ~st_q.rdp;
            st_d.ovf            = 1'b0;
        end
        if (wr && !st_d.ovf) begin
            st_d.data[st_q.fill][{st_q.cnt, 3'b000} +: 8] = wbyte;
            if (st_q.cnt == LAST) begin
                st_d.cnt             = '0;
                st_d.full[st_q.fill] = 1'b1;
                st_d.fill            = ~st_q.fill;
                if (st_d.full[~st_q.fill]) st_d.ovf = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdy     = st_q.full[st_q.rdp];
    assign rd_data = st_q.data[st_q.rdp];
    assign ovf     = st_q.ovf;

    // R6: presented half stays put until released
    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !ack) |=> (rdy && $stable(rd_data)));
    // R7: overflow only while both halves await the consumer
    a_r7_ovf_both_full: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (st_q.full == 2'b11));
    // R7: acknowledge clears overflow
    a_r7_ack_clears_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && ack) |=> !ovf);
endmodule

// File: rtl/ts_byte_router.sv
module ts_byte_router
    import rxr_pkg::*;
#(
    parameter int SLOT_W      = 7,
    parameter int HDLC_CH     = 4,
    parameter int VOICE_WORDS = 2,
    parameter int HDLC_WORDS  = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          lut_we,
    input  logic [SLOT_W-1:0]             lut_addr,
    input  logic [1:0]                    lut_class,
    input  logic                          fsize_we,
    input  logic [SLOT_W-1:0]             fsize,
    input  logic                          in_valid,
    input  logic [SLOT_W-1:0]             in_slot,
    input  logic [7:0]                    in_byte,
    output logic                          voice_rdy,
    output logic [VOICE_WORDS*32-1:0]     voice_rd_data,
    input  logic                          voice_ack,
    output logic                          voice_ovf,
    output logic [HDLC_CH-1:0]            hdlc_rdy,
    output logic [HDLC_CH*HDLC_WORDS*32-1:0] hdlc_rd_data,
    input  logic [HDLC_CH-1:0]            hdlc_ack,
    output logic [HDLC_CH-1:0]            hdlc_ovf
);
    localparam int CH_W = (HDLC_CH > 1) ? $clog2(HDLC_CH) : 1;
    localparam int HBW  = HDLC_WORDS * 32;

    slot_class_t        cls;
    logic               voice_wr;
    logic [HDLC_CH-1:0] hdlc_wr;

    rxr_class_table #(.SLOT_W(SLOT_W)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .we(lut_we), .waddr(lut_addr), .wclass(lut_class),
        .fs_we(fsize_we), .fs_val(fsize),
        .look_slot(in_slot), .look_class(cls)
    );

    assign voice_wr = in_valid && (cls == SC_VOICE || cls == SC_K56);

    rxr_pingpong #(.WORDS(VOICE_WORDS)) u_voice (
        .clk(clk), .rst_n(rst_n), .wr(voice_wr), .wbyte(in_byte),
        .ack(voice_ack), .rdy(voice_rdy), .rd_data(voice_rd_data), .ovf(voice_ovf)
    );

    for (genvar c = 0; c < HDLC_CH; c++) begin : g_hdlc
        assign hdlc_wr[c] = in_valid && (cls == SC_HDLC) && (in_slot[CH_W-1:0] == CH_W'(c));
        rxr_pingpong #(.WORDS(HDLC_WORDS)) u_ch (
            .clk(clk), .rst_n(rst_n), .wr(hdlc_wr[c]), .wbyte(in_byte),
            .ack(hdlc_ack[c]), .rdy(hdlc_rdy[c]),
            .rd_data(hdlc_rd_data[c*HBW +: HBW]), .ovf(hdlc_ovf[c])
        );
    end

    // R4: a byte lands in at most one buffer
    a_r4_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({voice_wr, hdlc_wr}));
    // R2: nothing is stored without an input byte
    a_r2_no_spurious_write: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ({voice_wr, hdlc_wr} == '0));
endmodule

// File: tb/tb_ts_byte_router.sv
`timescale 1ns/1ps
module tb_ts_byte_router;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lut_we = 1'b0;
    logic [6:0]   lut_addr = '0;
    logic [1:0]   lut_class = '0;
    logic         fsize_we = 1'b0;
    logic [6:0]   fsize = '0;
    logic         in_valid = 1'b0;
    logic [6:0]   in_slot = '0;
    logic [7:0]   in_byte = '0;
    logic         voice_rdy;
    logic [63:0]  voice_rd_data;
    logic         voice_ack = 1'b0;
    logic         voice_ovf;
    logic [3:0]   hdlc_rdy;
    logic [127:0] hdlc_rd_data;
    logic [3:0]   hdlc_ack = '0;
    logic [3:0]   hdlc_ovf;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Class per slot 0..15: 0 none, 1 voice, 2 HDLC, 3 56-K; slots 12..15 lie beyond the frame
    localparam logic [1:0] TBL [16] = '{2'd1, 2'd3, 2'd2, 2'd2, 2'd2, 2'd1, 2'd2, 2'd0,
                                        2'd1, 2'd2, 2'd2, 2'd2, 2'd1, 2'd1, 2'd2, 2'd2};
    localparam int FRAME = 12;

    logic [7:0] vq [$];
    logic [7:0] hq [4][$];

    always #2.5 clk = ~clk;

    ts_byte_router dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic send(input logic [6:0] s, input logic [7:0] b);
        in_valid = 1'b1; in_slot = s; in_byte = b;
        tick();
        in_valid = 1'b0;
    endtask

    task automatic wr_lut(input logic [6:0] a, input logic [1:0] c);
        lut_we = 1'b1; lut_addr = a; lut_class = c;
        tick();
        lut_we = 1'b0;
    endtask

    task automatic drain();
        logic [63:0] e;
        if (voice_rdy) begin
            e = '0;
            for (int i = 0; i < 8; i++) e[i*8 +: 8] = (vq.size() > 0) ? vq.pop_front() : 8'hxx;
            chk(voice_rd_data === e, "R3 voice half", voice_rd_data, e);
            voice_ack = 1'b1; tick(); voice_ack = 1'b0;
        end
        for (int c = 0; c < 4; c++) begin
            if (hdlc_rdy[c]) begin
                e = '0;
                for (int i = 0; i < 4; i++) e[i*8 +: 8] = (hq[c].size() > 0) ? hq[c].pop_front() : 8'hxx;
                chk(hdlc_rd_data[c*32 +: 32] === e[31:0], "R4 hdlc word",
                    {32'd0, hdlc_rd_data[c*32 +: 32]}, e);
                hdlc_ack[c] = 1'b1; tick(); hdlc_ack[c] = 1'b0;
            end
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] w0, w1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R8: reset state
        chk({voice_rdy, voice_ovf, hdlc_rdy, hdlc_ovf} == '0, "R8 flags after reset",
            {54'd0, voice_rdy, voice_ovf, hdlc_rdy, hdlc_ovf}, 64'd0);
        // R8/R2: entries start unassigned, so nothing is stored
        for (int s = 0; s < 16; s++) send(7'(s), 8'hA0 + 8'(s));
        chk({voice_rdy, hdlc_rdy} == '0, "R8 table unassigned after reset",
            {59'd0, voice_rdy, hdlc_rdy}, 64'd0);

        // R1: program the table and a 12-slot frame
        for (int s = 0; s < 16; s++) wr_lut(7'(s), TBL[s]);
        fsize_we = 1'b1; fsize = 7'(FRAME); tick(); fsize_we = 1'b0;

        // Main stream: walk the table for 8 frames, reference queues per class
        for (int f = 0; f < 8; f++) begin
            for (int s = 0; s < 16; s++) begin
                logic [7:0] b;
                b = 8'(f * 16 + s + 1);
                send(7'(s), b);
                if (s < FRAME) begin
                    if (TBL[s] == 2'd1 || TBL[s] == 2'd3) vq.push_back(b);
                    else if (TBL[s] == 2'd2) hq[s % 4].push_back(b);
                end
                drain();
            end
        end
        // R5/R2: slots past the frame and unassigned slot 7 added nothing
        chk(vq.size() == 0 && hq[0].size() == 0 && hq[1].size() == 0 &&
            hq[2].size() == 0 && hq[3].size() == 0, "R5 queues fully consumed",
            64'(vq.size() + hq[2].size()), 64'd0);
        chk({voice_rdy, hdlc_rdy} == '0, "R5 no leftover half", {59'd0, voice_rdy, hdlc_rdy}, 64'd0);

        // R5: frame size 0 makes slot 127 live
        wr_lut(7'd127, 2'd1);
        fsize_we = 1'b1; fsize = 7'd0; tick(); fsize_we = 1'b0;
        for (int i = 0; i < 8; i++) send(7'd127, 8'hC0 + 8'(i));
        chk(voice_rdy == 1'b1, "R5 slot 127 live with size 0", {63'd0, voice_rdy}, 64'd1);
        chk(voice_rd_data == 64'hC7C6C5C4C3C2C1C0, "R5 slot 127 data", voice_rd_data, 64'hC7C6C5C4C3C2C1C0);
        voice_ack = 1'b1; tick(); voice_ack = 1'b0;

        // R7: overflow on HDLC channel 1 (slot 9)
        for (int i = 0; i < 4; i++) send(7'd9, 8'h10 + 8'(i));
        chk(hdlc_rdy[1] && !hdlc_ovf[1], "R6 first half ready", {62'd0, hdlc_rdy[1], hdlc_ovf[1]}, 64'd2);
        repeat (3) tick();
        chk(hdlc_rd_data[63:32] == 32'h13121110, "R6 data held until ack",
            {32'd0, hdlc_rd_data[63:32]}, 64'h13121110);
        for (int i = 0; i < 4; i++) send(7'd9, 8'h20 + 8'(i));
        chk(hdlc_ovf[1] == 1'b1, "R7 overflow set", {63'd0, hdlc_ovf[1]}, 64'd1);
        send(7'd9, 8'hEE); send(7'd9, 8'hEF);
        w0 = hdlc_rd_data[63:32];
        chk(w0 == 32'h13121110, "R7 first half intact", {32'd0, w0}, 64'h13121110);
        hdlc_ack[1] = 1'b1; tick(); hdlc_ack[1] = 1'b0;
        chk(!hdlc_ovf[1] && hdlc_rdy[1], "R7 ack clears overflow", {62'd0, hdlc_ovf[1], hdlc_rdy[1]}, 64'd1);
        w1 = hdlc_rd_data[63:32];
        chk(w1 == 32'h23222120, "R6 second half in order", {32'd0, w1}, 64'h23222120);
        hdlc_ack[1] = 1'b1; tick(); hdlc_ack[1] = 1'b0;
        chk(hdlc_rdy[1] == 1'b0, "R6 empty after both acks", {63'd0, hdlc_rdy[1]}, 64'd0);
        for (int i = 0; i < 4; i++) send(7'd9, 8'h30 + 8'(i));
        chk(hdlc_rdy[1] && hdlc_rd_data[63:32] == 32'h33323130, "R7 dropped bytes absent",
            {32'd0, hdlc_rd_data[63:32]}, 64'h33323130);

        // R1: reclassify slot 7 as HDLC (channel 3)
        wr_lut(7'd7, 2'd2);
        for (int i = 0; i < 4; i++) send(7'd7, 8'h40 + 8'(i));
        chk(hdlc_rdy[3] && hdlc_rd_data[127:96] == 32'h43424140, "R1 rewritten entry used",
            {32'd0, hdlc_rd_data[127:96]}, 64'h43424140);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule